// File: doc/BRIEF.md
# UART transmitter with bus driver enable

This block is an asynchronous serial transmitter meant to drive a half-duplex bus transceiver such as RS-485. The host writes a byte into a one-entry holding register. The block frames the byte with a start bit, an optional even or odd parity bit and one or two stop bits. It shifts the frame out least significant bit first. The bit time is set by a 16-bit divisor that counts system clocks per bit. The line idles high.

A driver-enable output turns the external transceiver on for the whole frame. It rises on the clock after a byte is accepted. The start bit then waits at least one full bit period, so the transceiver has time to settle. Driver enable falls one clock after the final stop bit. It does not fall between characters when the next byte was written in time. Its polarity is programmable.

An optional clear-to-send input lets a remote receiver hold off the next character. The input is examined only in the clock just before a start bit would go out. A character that has already started is always sent in full.

Top module: `uart_de_tx`

## Requirements
- R1: After reset, `txd` is 1, `de` is at its inactive level (0 when `de_active_low` is 0) and `tx_empty` is 1.
- R2: A frame is a start bit of 0, then the 8 data bits with bit 0 first, then the parity bit if one is enabled, then the stop bits of 1. Each bit lasts `baud_div` clocks.
- R3: With `parity_en`=1, the parity bit follows data bit 7. It is the XOR of the data bits when `parity_odd`=0, and the inverse of that XOR when `parity_odd`=1.
- R4: `two_stop`=0 sends one stop bit and `two_stop`=1 sends two.
- R5: The clock after an accepted write starting from idle, `de` is active. The start bit begins no fewer than `baud_div` and no more than `2*baud_div` clocks after `de` becomes active.
- R6: `de` stays active during the clock that follows the last clock of the final stop bit. In the clock after that it is inactive, if no byte is waiting.
- R7: A byte written while the previous frame is still going out gets a start bit that directly follows the last stop bit. `de` stays active without a gap across both frames.
- R8: With `cts_en`=1, a start bit is issued only if `cts` was 1 in the clock before it. While `cts` is 0 the line stays idle and `de` stays active. With `cts_en`=0, `cts` has no effect.
- R9: A frame already started is sent completely even if `cts` falls during it.
- R10: With `de_active_low`=1, `de` is 0 when active and 1 when inactive.
- R11: `tx_empty` is 1 exactly when the holding register is free. A write while `tx_empty` is 0 is ignored, so the byte is never transmitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_div | input | 16 | System clocks per bit (0 acts as 1) |
| parity_en | input | 1 | Append a parity bit |
| parity_odd | input | 1 | 1 selects odd parity, 0 selects even |
| two_stop | input | 1 | 1 selects two stop bits |
| cts_en | input | 1 | Enable clear-to-send flow control |
| cts | input | 1 | Clear to send, 1 = allowed |
| de_active_low | input | 1 | 1 makes `de` active low |
| wr_en | input | 1 | Write strobe for `wr_data` |
| wr_data | input | 8 | Byte to transmit |
| tx_empty | output | 1 | Holding register can accept a byte |
| txd | output | 1 | Serial data out, idle 1 |
| de | output | 1 | Transceiver driver enable |

## Verification
The hardest case to reach from the ports is a back-to-back pair of characters. The second byte has to land in the holding register while the first frame is on the wire. Then a third write has to hit the full register and be dropped. To get there, the bench polls `tx_empty` until the first frame's start bit releases the register. It writes the second and third bytes a few clocks into that frame. It then walks clock by clock to the boundary and confirms that the next start bit follows the last stop bit with `de` held throughout. A second hard case is flow control. The bench holds `cts` low across several bit periods while the lead time expires, and confirms that the line stays idle under an active `de`. It also drops `cts` mid-frame to confirm that the frame still completes.

// File: rtl/uart_de_tx.sv
module uart_de_tx #(
  parameter int DIV_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  baud_div,
  input  logic              parity_en,
  input  logic              parity_odd,
  input  logic              two_stop,
  input  logic              cts_en,
  input  logic              cts,
  input  logic              de_active_low,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              tx_empty,
  output logic              txd,
  output logic              de
);
  localparam int FRAME_W = DATA_W + 4;
  localparam int IDX_W   = $clog2(FRAME_W + 1);

  typedef enum logic [2:0] {S_IDLE, S_LEAD, S_READY, S_SEND, S_HOLD} state_t;

  state_t              state;
  logic [DIV_W-1:0]    baud_cnt, lead_cnt;
  logic [DATA_W-1:0]   hold_q;
  logic                hold_full;
  logic [FRAME_W-1:0]  shreg, frame_w;
  logic [IDX_W-1:0]    bit_idx, frame_len;

  wire [DIV_W-1:0] div_m1   = (baud_div == '0) ? '0 : baud_div - DIV_W'(1);
  wire             tick     = baud_cnt >= div_m1;
  wire             cts_ok   = !cts_en || cts;
  wire             wr_ok    = wr_en && !hold_full;
  wire             in_send  = state == S_SEND;
  wire             last_bit = bit_idx == frame_len - IDX_W'(1);
  wire             start_frame = hold_full && cts_ok && tick &&
                                 (state == S_READY || (in_send && last_bit));
  wire             de_raw   = state != S_IDLE;
  wire [IDX_W-1:0] new_len  = IDX_W'(DATA_W + 2) + IDX_W'(parity_en) + IDX_W'(two_stop);

  assign tx_empty = !hold_full;
  assign txd      = in_send ? shreg[0] : 1'b1;
  assign de       = de_raw ^ de_active_low;

  always_comb begin
    frame_w = '1;
    frame_w[0] = 1'b0;
    frame_w[DATA_W:1] = hold_q;
    if (parity_en) frame_w[DATA_W+1] = (^hold_q) ^ parity_odd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) baud_cnt <= '0;
    else        baud_cnt <= tick ? '0 : baud_cnt + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q    <= '0;
      hold_full <= 1'b0;
    end else if (start_frame) begin
      hold_full <= 1'b0;
    end else if (wr_ok) begin
      hold_q    <= wr_data;
      hold_full <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      lead_cnt <= '0;
    end else begin
      case (state)
        S_IDLE, S_HOLD: begin
          lead_cnt <= '0;
          state    <= (wr_ok || hold_full) ? S_LEAD : S_IDLE;
        end
        S_LEAD: begin
          if (lead_cnt >= div_m1) state <= S_READY;
          else lead_cnt <= lead_cnt + DIV_W'(1);
        end
        S_READY: if (start_frame) state <= S_SEND;
        S_SEND: begin
          if (tick && last_bit && !start_frame)
            state <= hold_full ? S_READY : S_HOLD;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg     <= '1;
      bit_idx   <= '0;
      frame_len <= IDX_W'(DATA_W + 2);
    end else if (start_frame) begin
      shreg     <= frame_w;
      bit_idx   <= '0;
      frame_len <= new_len;
    end else if (in_send && tick) begin
      shreg     <= {1'b1, shreg[FRAME_W-1:1]};
      bit_idx   <= bit_idx + IDX_W'(1);
    end
  end

  // R5
  start_after_de_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(txd) |-> de_raw && $past(de_raw));

  // R6
  de_release_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(de_raw) |-> txd && $past(txd) && $past(txd, 2));

  // R8
  cts_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_send) |-> $past(!cts_en || cts));

  // R9
  frame_no_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_send && !(tick && last_bit)) |=> in_send);

  // R11
  write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !tx_empty && !start_frame) |=> $stable(hold_q));
endmodule

// File: tb/uart_de_tx_tb_top.sv
module uart_de_tx_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] baud_div = 16'd4;
  logic parity_en = 0, parity_odd = 0, two_stop = 0, cts_en = 0, cts = 1, de_active_low = 0;
  logic wr_en = 0;
  logic [7:0] wr_data = '0;
  logic tx_empty, txd, de;

  int checks = 0, errors = 0, cyc = 0, cur_div = 4;
  logic [15:0] exp_q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  uart_de_tx dut_i (.clk(clk), .rst_n(rst_n), .baud_div(baud_div), .parity_en(parity_en),
    .parity_odd(parity_odd), .two_stop(two_stop), .cts_en(cts_en), .cts(cts),
    .de_active_low(de_active_low), .wr_en(wr_en), .wr_data(wr_data),
    .tx_empty(tx_empty), .txd(txd), .de(de));

  function automatic logic de_on();
    return (de ^ de_active_low) === 1'b1;
  endfunction

  function automatic logic [15:0] exp_frame(logic [7:0] d);
    logic [11:0] b = '1;
    int n = 10 + int'(parity_en) + int'(two_stop);
    b[0] = 1'b0;
    for (int i = 0; i < 8; i++) b[i+1] = d[i];
    if (parity_en) b[9] = parity_odd ? ~(^d) : (^d);
    return {4'(n), b};
  endfunction

  task automatic check(input string req, input logic ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_byte(input logic [7:0] d);
    @(negedge clk); wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_start(output int found);
    found = 0;
    for (int i = 0; i < 8 * cur_div + 40 && found == 0; i++) begin
      @(negedge clk);
      if (txd === 1'b0) found = 1;
    end
  endtask

  task automatic run_frame(input logic [7:0] d, input string req);
    int c_de, c_st, lead, len, found;
    logic [15:0] e = exp_frame(d);
    len = int'(e[15:12]);
    exp_q.push_back(e);
    write_byte(d);
    check("R5 de on after write", de_on(), int'(de), int'(!de_active_low));
    c_de = cyc;
    wait_start(found);
    c_st = cyc;
    lead = c_st - c_de;
    check({"R5 lead ", req}, found == 1 && lead >= cur_div && lead <= 2 * cur_div, lead, cur_div);
    repeat (len * cur_div) @(negedge clk);
    check({"R6 de held one clock ", req}, de_on() && txd === 1'b1, int'(de), int'(!de_active_low));
    @(negedge clk);
    check({"R6 de released ", req}, !de_on(), int'(de), int'(de_active_low));
  endtask

  // scoreboard monitor
  initial begin
    wait (rst_n);
    forever begin
      @(negedge clk);
      if (txd === 1'b0) begin
        logic [15:0] e;
        logic [11:0] got, m;
        int len, d;
        logic de_bad;
        d = cur_div; got = '1; de_bad = 1'b0;
        if (exp_q.size() == 0) begin
          check("R11 unexpected frame", 1'b0, 1, 0);
          while (txd !== 1'b1) @(negedge clk);
        end else begin
          e = exp_q.pop_front();
          len = int'(e[15:12]);
          repeat (d / 2) @(negedge clk);
          for (int j = 0; j < len; j++) begin
            got[j] = txd;
            if (!de_on()) de_bad = 1'b1;
            if (j < len - 1) repeat (d) @(negedge clk);
          end
          repeat (d - d / 2 - 1) @(negedge clk);
          m = 12'((1 << len) - 1);
          check("R2 R3 R4 frame bits", (got & m) == (e[11:0] & m), int'(got & m), int'(e[11:0] & m));
          check("R7 de across frame", !de_bad, 0, 1);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int found, gaps, len;
    repeat (3) @(negedge clk);
    check("R1 txd idle", txd === 1'b1, int'(txd), 1);
    check("R1 de inactive", de === 1'b0, int'(de), 0);
    check("R1 tx_empty", tx_empty === 1'b1, int'(tx_empty), 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R4 plain frame, one stop bit
    run_frame(8'hA5, "8N1");
    // R3 even parity
    parity_en = 1; run_frame(8'h37, "even");
    // R3 odd parity, R4 two stop
    parity_odd = 1; two_stop = 1; run_frame(8'hC2, "odd 2stop");
    parity_en = 0; parity_odd = 0;
    // R4 two stop without parity, other divisor
    baud_div = 16'd5; cur_div = 5; run_frame(8'h01, "div5");
    baud_div = 16'd4; cur_div = 4; two_stop = 0;

    // R10 active-low driver enable
    de_active_low = 1; @(negedge clk);
    check("R10 idle level", de === 1'b1, int'(de), 1);
    run_frame(8'h5A, "R10");
    check("R10 released level", de === 1'b1, int'(de), 1);
    de_active_low = 0;

    // R7 back to back, R11 write while full ignored
    len = 10;
    exp_q.push_back(exp_frame(8'h11));
    write_byte(8'h11);
    found = 0;
    for (int i = 0; i < 60 && tx_empty !== 1'b1; i++) @(negedge clk);
    check("R11 empty at start", tx_empty === 1'b1 && txd === 1'b0, int'(tx_empty), 1);
    exp_q.push_back(exp_frame(8'h2C));
    gaps = 0;
    write_byte(8'h2C);
    check("R11 full after write", tx_empty === 1'b0, int'(tx_empty), 0);
    write_byte(8'hEE);
    check("R11 still full", tx_empty === 1'b0, int'(tx_empty), 0);
    for (int i = 4; i < len * cur_div; i++) begin
      @(negedge clk);
      if (!de_on()) gaps++;
    end
    check("R7 next start follows stop", txd === 1'b0, int'(txd), 0);
    for (int i = 0; i < len * cur_div; i++) begin
      if (!de_on()) gaps++;
      @(negedge clk);
    end
    check("R7 no de gap", gaps == 0, gaps, 0);
    check("R6 de held after pair", de_on(), int'(de), 1);
    @(negedge clk);
    check("R6 de off after pair", !de_on(), int'(de), 0);

    // R8 clear-to-send holds the frame
    cts_en = 1; cts = 0;
    exp_q.push_back(exp_frame(8'h99));
    write_byte(8'h99);
    found = 0;
    for (int i = 0; i < 6 * cur_div; i++) begin
      @(negedge clk);
      if (txd !== 1'b1 || !de_on()) found = 1;
    end
    check("R8 held by cts", found == 0, found, 0);
    cts = 1;
    wait_start(found);
    check("R8 starts after cts", found == 1, found, 1);
    repeat (11 * cur_div) @(negedge clk);
    check("R8 back to idle", !de_on() && txd === 1'b1, int'(de), 0);

    // R9 cts drop mid frame
    exp_q.push_back(exp_frame(8'h6B));
    write_byte(8'h6B);
    wait_start(found);
    repeat (3 * cur_div) @(negedge clk);
    cts = 0;
    repeat (8 * cur_div) @(negedge clk);
    check("R9 frame completed", !de_on() && txd === 1'b1, int'(de), 0);
    cts = 1;

    // R8 cts ignored when disabled
    cts_en = 0; cts = 0;
    run_frame(8'h80, "R8 cts off");
    cts = 1;

    repeat (4 * cur_div) @(negedge clk);
    check("R2 all frames seen", exp_q.size() == 0, exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule